// File: doc/BRIEF.md
# Grouped Edge Interrupt Collector

This block gathers a wide field of edge-triggered interrupt sources and sorts them into banks of 32. Source `k` lands in bank `k/32` at bit `k%32`. Every bank keeps one latched pending word and one mask word, and raises its own outgoing interrupt line while any unmasked source in it is pending. The number of banks is a parameter from 1 to 8.

Software uses a small 32-bit register port with single-cycle reads and writes. It reads a bank's pending word to find out which sources fired. It acknowledges them by writing ones. It masks or unmasks single sources by reading, changing and writing back the mask word. Each source input passes through a two-stage synchronizer and a rising-edge detector before it reaches the pending logic, so the sources may be asynchronous to the clock.

The external reset is asserted asynchronously and released through a two-flop synchronizer inside the block.

Top module: `vec_agg_ctrl`

## Requirements
- R1: Source input `k` maps to bank `k/32`, bit `k%32`. The pending word of bank `i` is read at byte offset `4*i`.
- R2: The mask word of bank `i` is at byte offset `0x20 + 4*i`. It reads back exactly what was last written to it. A bit value of 1 means the source is enabled.
- R3: A rising edge on an enabled source sets its pending bit within four clock edges. A source that stays high sets the bit only once.
- R4: An edge on a source whose enable bit is 0 is discarded. Enabling that source afterwards, while its input stays high, leaves the pending bit clear.
- R5: A write to a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When a new edge reaches the pending logic in the same cycle as an acknowledge of that bit, the bit stays set.
- R7: Line `i` is high exactly when the pending word of bank `i` ANDed with its mask word is nonzero. The line is low at the first falling clock edge after the write that clears the last such bit.
- R8: Reads return zero for offsets of banks at or above the configured count, for offsets `0x40` and above, and for offsets that are not multiples of 4. Writes to any of those offsets change no state.
- R9: After reset, every pending word and every mask word reads zero, and every line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vec_in | input | GROUPS*32 | Edge-triggered source inputs, asynchronous to clk |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when reg_sel is low |
| irq_out | output | GROUPS | One interrupt line per bank |

## Verification
The two functions that can land in the same cycle are a source edge setting a pending bit and a software acknowledge clearing it. The bench provokes the collision by raising a source and counting out the synchronizer and edge-detector stages. It then times the write-one-to-clear so that it is sampled on exactly the edge where the detected edge reaches the pending logic. The same write also clears a second, idle pending bit. The result is judged by reading the pending word back: the colliding bit must remain set and the idle bit must be gone.

// File: rtl/vagg_pkg.sv
package vagg_pkg;
  localparam int unsigned GW         = 32;  // sources per bank
  localparam int unsigned MAX_GROUPS = 8;
  localparam int unsigned EN_WORD    = 8;   // word index of first mask word (0x20)
  localparam int unsigned TOP_WORD   = 16;  // first unmapped word (0x40)
  typedef logic [GW-1:0] bank_word_t;
endpackage

// File: rtl/vagg_sync_edge.sv
module vagg_sync_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta_q, stab_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign rise = stab_q & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0)); // R3
endmodule

// File: rtl/vagg_group.sv
module vagg_group
  import vagg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bank_word_t rise,
  input  logic       pend_we,
  input  logic       en_we,
  input  bank_word_t wdata,
  output bank_word_t pend_q,
  output bank_word_t en_q,
  output logic       irq
);
  bank_word_t pend_d, en_d, set_v, clr_v;

  always_comb begin
    set_v  = rise & en_q;
    clr_v  = pend_we ? wdata : '0;
    pend_d = (pend_q & ~clr_v) | set_v;
    en_d   = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign irq = |(pend_q & en_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> ((pend_q & $past(wdata & ~set_v)) == '0)); // R5
  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0)); // R4
endmodule

// File: rtl/vec_agg_ctrl.sv
module vec_agg_ctrl
  import vagg_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] vec_in,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [GROUPS-1:0]    irq_out
);
  localparam int unsigned NV = GROUPS * GW;
  localparam int unsigned WW = AW - 2;

  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [NV-1:0] rise_all;
  vagg_sync_edge #(.N(NV)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .async_in(vec_in), .rise(rise_all)
  );

  logic [WW-1:0] word;
  logic          aligned;
  assign word    = reg_addr[AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  bank_word_t pend_arr [GROUPS];
  bank_word_t en_arr   [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    logic pw, ew;
    assign pw = reg_sel & reg_wr & aligned & (word == WW'(g));
    assign ew = reg_sel & reg_wr & aligned & (word == WW'(EN_WORD + g));
    vagg_group u_grp (
      .clk(clk), .rst_n(rst_s_q),
      .rise(rise_all[g*GW +: GW]),
      .pend_we(pw), .en_we(ew), .wdata(reg_wdata),
      .pend_q(pend_arr[g]), .en_q(en_arr[g]), .irq(irq_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr && aligned) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (word == WW'(g))           reg_rdata = pend_arr[g];
        if (word == WW'(EN_WORD + g)) reg_rdata = en_arr[g];
      end
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_s_q)
    (reg_sel && !reg_wr && (int'(word) >= TOP_WORD)) |-> (reg_rdata == '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!reg_sel) |-> (reg_rdata == '0)); // R8
  AST_PARAM_RANGE: assert property (@(posedge clk)
    (GROUPS >= 1) && (GROUPS <= MAX_GROUPS) && (AW >= 7)); // R1
endmodule

// File: tb/sim_vec_agg_ctrl.sv
`timescale 1ns/1ps
module sim_vec_agg_ctrl;
  localparam int G  = 6;
  localparam int NV = G * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NV-1:0] vec;
  logic          sel, wr;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [G-1:0]  irq;

  int checks = 0, fails = 0;
  logic [31:0] m_pend [G];
  logic [31:0] m_en   [G];

  always #4 clk = ~clk;

  vec_agg_ctrl #(.GROUPS(G), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .vec_in(vec), .reg_sel(sel), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  function automatic logic [G-1:0] exp_irq();
    logic [G-1:0] r;
    for (int g = 0; g < G; g++) r[g] = |(m_pend[g] & m_en[g]);
    return r;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int g = 0; g < G; g++) begin
      bus_rd(8'(4*g), d);        chk(req, d, m_pend[g]);
      bus_rd(8'(32 + 4*g), d);   chk(req, d, m_en[g]);
    end
    @(negedge clk); chk({req, " irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  // raise bits (only rising), let them settle, then update the model
  task automatic raise(input logic [NV-1:0] up);
    logic [NV-1:0] r;
    r = up & ~vec;
    @(negedge clk); vec = vec | up;
    repeat (6) @(posedge clk);
    for (int g = 0; g < G; g++) m_pend[g] |= r[g*32 +: 32] & m_en[g];
  endtask

  task automatic lower(input logic [NV-1:0] keep);
    @(negedge clk); vec = vec & keep;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'h5eed_1234));
    sel = 0; wr = 0; addr = 0; wdata = 0; vec = '0; rst_n = 0;
    for (int g = 0; g < G; g++) begin m_pend[g] = 0; m_en[g] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R9 reset state
    check_all("R9");

    // R4 masked edge dropped, later enable does not resurrect it
    raise(NV'(1) << (32 + 7));
    bus_wr(8'h24, 32'h0000_0080); m_en[1] = 32'h80;
    repeat (4) @(posedge clk);
    check_all("R4");
    lower('0);

    // R1/R2/R3 mapping: enable all, raise one bit per bank
    for (int g = 0; g < G; g++) begin
      bus_wr(8'(32 + 4*g), 32'hFFFF_FFFF); m_en[g] = 32'hFFFF_FFFF;
    end
    for (int g = 0; g < G; g++) raise(NV'(1) << (g*32 + (g*5) % 32));
    check_all("R1");
    // R3 held high: clear then wait, no re-set
    for (int g = 0; g < G; g++) begin bus_wr(8'(4*g), 32'hFFFF_FFFF); m_pend[g] = 0; end
    repeat (8) @(posedge clk);
    check_all("R3");
    lower('0);

    // R7 line drops right after last enabled bit cleared
    raise(NV'(3));
    @(negedge clk); chk("R7 up", 32'(irq[0]), 32'd1);
    bus_wr(8'h00, 32'h1); m_pend[0] &= ~32'h1;
    chk("R7 still", 32'(irq[0]), 32'd1);
    @(negedge clk); sel = 1; wr = 1; addr = 8'h00; wdata = 32'h2;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0; m_pend[0] = 0;
    chk("R7 drop", 32'(irq[0]), 32'd0);
    // R7 masking a pending source drops the line, pending stays
    raise(NV'(1) << 40);
    bus_wr(8'h24, 32'hFFFF_FEFF); m_en[1] = 32'hFFFF_FEFF;
    check_all("R7");
    bus_wr(8'h24, 32'hFFFF_FFFF); m_en[1] = 32'hFFFF_FFFF;
    lower('0);

    // R5 partial acknowledge
    raise(NV'(32'hF0F0_000F));
    bus_wr(8'h00, 32'h0000_0005); m_pend[0] &= ~32'h5;
    check_all("R5");
    lower('0);

    // R6 edge collides with acknowledge
    raise(NV'(32'h40));              // bit 6 pending
    @(negedge clk); vec[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1; wr = 1; addr = 8'h00; wdata = 32'h60;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0;
    m_pend[0] = (m_pend[0] & ~32'h60) | 32'h20;
    bus_rd(8'h00, d); chk("R6", d & 32'h60, 32'h20);
    check_all("R6");
    lower('0);

    // R8 unmapped / absent banks
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h38, 32'hFFFF_FFFF);
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_wr(8'h21, 32'h0);           // misaligned: enable of bank 0 must stay
    bus_rd(8'h18, d); chk("R8 bank6 pend", d, 32'h0);
    bus_rd(8'h38, d); chk("R8 bank6 en", d, 32'h0);
    bus_rd(8'h40, d); chk("R8 0x40", d, 32'h0);
    bus_rd(8'hFC, d); chk("R8 0xFC", d, 32'h0);
    bus_rd(8'h22, d); chk("R8 misaligned", d, 32'h0);
    check_all("R8");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int g;
      g = $urandom_range(G-1);
      case ($urandom_range(3))
        0: begin v = $urandom; bus_wr(8'(32 + 4*g), v); m_en[g] = v; end
        1: begin v = $urandom; bus_wr(8'(4*g), v); m_pend[g] &= ~v; end
        2: begin v = $urandom; raise(NV'(v) << (g*32)); end
        default: lower(NV'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}));
      endcase
      if (it % 8 == 7) check_all("R5 rnd");
    end
    check_all("R3 rnd");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule